// File: doc/BRIEF.md
# Auto-Repeat Push-Button Stepper with Saturating Level Counter

This block converts two push-button inputs, raise and lower, into count steps for a 12-bit level register whose value feeds a DAC. A fresh press moves the level by one step at once. If the same button is still held after a hold-off window, the block keeps stepping at a fixed fast rate until the button is released. Both time bases come from the system clock through a free-running prescaler: a fast tick every `FAST_DIV` cycles, and a slow tick every `SLOW_DIV` fast ticks.

A second stepper uses the same logic on a single meter button and the slow tick. It advances a 4-bit meter selection register, which rolls over from 15 to 0. Buttons are expected to be debounced before they reach this block. With the default parameters and a clock near 77.6 kHz, the fast tick runs near 300 Hz, the level hold-off is about 2 s, and the meter repeats about once every 1.17 s.

Top module: `stepctl_top`

## Requirements
- R1: While `rst_n` is low, `level` and `meter_sel` are 0 and neither step output is high.
- R2: When exactly one of `up_btn`/`dn_btn` is seen high while the level stepper is idle, `level_step` is high for one cycle in the next cycle, and `level` changes by one in the cycle after that.
- R3: When the button stays held, the next level step falls on the `HOLD_TICKS`-th fast tick after the press. After that, a step falls on every `LEVEL_RPT_TICKS`-th fast tick.
- R4: A step caused by `up_btn` raises `level` by one and a step caused by `dn_btn` lowers it by one. `level` never changes except one cycle after `level_step`.
- R5: `level` holds at 4095 on a raise step and holds at 0 on a lower step, and never wraps.
- R6: A cycle with both `up_btn` and `dn_btn` high issues no level step, and it ends any hold-off or repeat in progress.
- R7: A cycle with the held button low returns the stepper to idle at once, with no step, even when a tick falls on that cycle. A later press steps immediately.
- R8: The fast tick falls on every `FAST_DIV`-th clock edge after reset. The slow tick falls on every `FAST_DIV*SLOW_DIV`-th edge.
- R9: `meter_btn` steps `meter_sel` up by one at once on a press. While the button stays held it steps again on every `METER_TICKS`-th slow tick, and it wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_btn | input | 1 | Raise button, debounced, high while pressed |
| dn_btn | input | 1 | Lower button, debounced, high while pressed |
| meter_btn | input | 1 | Meter select button, debounced, high while pressed |
| level | output | 12 | Level code to the DAC |
| level_step | output | 1 | One-cycle pulse for each level step |
| meter_sel | output | 4 | Meter selection index |
| meter_step | output | 1 | One-cycle pulse for each meter step |

## Verification
A button release or a chord can arrive in the same cycle as a fast tick that would otherwise end the hold-off or issue a repeat step. In that case the release or chord must win, and no step may be issued. The random phase holds buttons for random lengths, so press and release edges land at many phases against the prescaler. A cycle-by-cycle reference model, built from the tick schedule and the requirements, judges every step pulse and every level value. Directed runs drive the level to both saturation limits and then apply a chord and a short tap there.

// File: rtl/stepctl_pkg.sv
package stepctl_pkg;
    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_HOLD = 2'd1,
        RP_RPT  = 2'd2
    } rp_state_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_s;

    div_s r_d, r_q;

    assign tick = en && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (en) begin
            if (r_q.cnt == LAST) r_d.cnt = '0;
            else                 r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/repeat_pulser.sv
module repeat_pulser
    import stepctl_pkg::*;
#(
    parameter int HOLD_TICKS = 600,
    parameter int RPT_TICKS  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_btn,
    input  logic dn_btn,
    input  logic tick,
    output logic step,
    output logic step_up
);
    localparam int MAXT = (HOLD_TICKS > RPT_TICKS) ? HOLD_TICKS : RPT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] RPT_LAST  = CW'(RPT_TICKS - 1);

    typedef struct packed {
        rp_state_e     st;
        logic [CW-1:0] cnt;
        logic          dir;
        logic          step;
    } rp_s;

    rp_s r_d, r_q;
    logic only_up, only_dn, held;
    logic [CW-1:0] lim;

    assign step    = r_q.step;
    assign step_up = r_q.dir;

    always_comb begin
        only_up = up_btn && !dn_btn;
        only_dn = dn_btn && !up_btn;
        held    = r_q.dir ? only_up : only_dn;
        lim     = (r_q.st == RP_HOLD) ? HOLD_LAST : RPT_LAST;
        r_d      = r_q;
        r_d.step = 1'b0;
        case (r_q.st)
            RP_IDLE: begin
                if (only_up || only_dn) begin
                    r_d.step = 1'b1;
                    r_d.dir  = only_up;
                    r_d.st   = RP_HOLD;
                    r_d.cnt  = '0;
                end
            end
            RP_HOLD, RP_RPT: begin
                if (!held) begin
                    r_d.st = RP_IDLE;
                end else if (tick) begin
                    if (r_q.cnt == lim) begin
                        r_d.step = 1'b1;
                        r_d.st   = RP_RPT;
                        r_d.cnt  = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RP_IDLE, cnt: '0, dir: 1'b0, step: 1'b0};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/updown_counter.sv
module updown_counter #(
    parameter int W        = 12,
    parameter bit SATURATE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] val;
    } cnt_s;

    cnt_s r_d, r_q;
    logic hold_up, hold_dn;

    assign value = r_q.val;

    generate
        if (SATURATE) begin : g_sat
            assign hold_up = (r_q.val == TOP);
            assign hold_dn = (r_q.val == '0);
        end else begin : g_wrap
            assign hold_up = 1'b0;
            assign hold_dn = 1'b0;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (step) begin
            if (up && !hold_up)       r_d.val = r_q.val + 1'b1;
            else if (!up && !hold_dn) r_d.val = r_q.val - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/stepctl_top.sv
module stepctl_top #(
    parameter int FAST_DIV        = 256,
    parameter int SLOW_DIV        = 32,
    parameter int HOLD_TICKS      = 600,
    parameter int LEVEL_RPT_TICKS = 1,
    parameter int METER_TICKS     = 11,
    parameter int LEVEL_W         = 12,
    parameter int METER_W         = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_btn,
    input  logic               dn_btn,
    input  logic               meter_btn,
    output logic [LEVEL_W-1:0] level,
    output logic               level_step,
    output logic [METER_W-1:0] meter_sel,
    output logic               meter_step
);
    logic fast_tick, slow_tick;
    logic lvl_up, mtr_up;

    tick_divider #(.DIV(FAST_DIV)) u_fast_div (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .tick(fast_tick)
    );

    tick_divider #(.DIV(SLOW_DIV)) u_slow_div (
        .clk(clk), .rst_n(rst_n), .en(fast_tick), .tick(slow_tick)
    );

    repeat_pulser #(.HOLD_TICKS(HOLD_TICKS), .RPT_TICKS(LEVEL_RPT_TICKS)) u_lvl_rep (
        .clk(clk), .rst_n(rst_n), .up_btn(up_btn), .dn_btn(dn_btn),
        .tick(fast_tick), .step(level_step), .step_up(lvl_up)
    );

    repeat_pulser #(.HOLD_TICKS(METER_TICKS), .RPT_TICKS(METER_TICKS)) u_mtr_rep (
        .clk(clk), .rst_n(rst_n), .up_btn(meter_btn), .dn_btn(1'b0),
        .tick(slow_tick), .step(meter_step), .step_up(mtr_up)
    );

    updown_counter #(.W(LEVEL_W), .SATURATE(1'b1)) u_lvl_cnt (
        .clk(clk), .rst_n(rst_n), .step(level_step), .up(lvl_up), .value(level)
    );

    updown_counter #(.W(METER_W), .SATURATE(1'b0)) u_mtr_cnt (
        .clk(clk), .rst_n(rst_n), .step(meter_step), .up(mtr_up), .value(meter_sel)
    );
endmodule

// File: rtl/stepctl_checker.sv
module stepctl_checker #(
    parameter int LEVEL_W = 12,
    parameter int METER_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               up_btn,
    input logic               dn_btn,
    input logic               meter_btn,
    input logic [LEVEL_W-1:0] level,
    input logic               level_step,
    input logic [METER_W-1:0] meter_sel,
    input logic               meter_step
);
    localparam logic [LEVEL_W-1:0] TOP = {LEVEL_W{1'b1}};

    a_r4_change_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> $past(level_step));

    a_r4_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |->
        ((LEVEL_W'(level - $past(level)) == LEVEL_W'(1)) ||
         (LEVEL_W'($past(level) - level) == LEVEL_W'(1))));

    a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level) == TOP) |-> (level != '0));

    a_r5_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level) == '0) |-> (level != TOP));

    a_r6_chord_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (up_btn && dn_btn) |=> !level_step);

    a_r7_release_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_btn && !dn_btn) |=> !level_step);

    a_r9_meter_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (meter_sel != $past(meter_sel)) |-> (meter_sel == METER_W'($past(meter_sel) + 1'b1)));

    a_r9_meter_release_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !meter_btn |=> !meter_step);
endmodule

bind stepctl_top stepctl_checker #(.LEVEL_W(LEVEL_W), .METER_W(METER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_btn(up_btn), .dn_btn(dn_btn), .meter_btn(meter_btn),
    .level(level), .level_step(level_step), .meter_sel(meter_sel), .meter_step(meter_step)
);

// File: tb/stepctl_top_test.sv
module stepctl_top_test;
    localparam int FD = 4;
    localparam int SD = 2;
    localparam int HT = 5;
    localparam int RT = 1;
    localparam int MT = 3;
    localparam int LMAX = 4095;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_btn = 1'b0, dn_btn = 1'b0, meter_btn = 1'b0;
    logic [11:0] level;
    logic [3:0]  meter_sel;
    logic level_step, meter_step;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stepctl_top #(.FAST_DIV(FD), .SLOW_DIV(SD), .HOLD_TICKS(HT),
                  .LEVEL_RPT_TICKS(RT), .METER_TICKS(MT)) uut (
        .clk(clk), .rst_n(rst_n), .up_btn(up_btn), .dn_btn(dn_btn), .meter_btn(meter_btn),
        .level(level), .level_step(level_step), .meter_sel(meter_sel), .meter_step(meter_step)
    );

    typedef struct {
        int st;
        int cnt;
        bit dir;
        bit step;
    } mdl_t;

    mdl_t lm, mm;
    int   m_level, m_meter, edge_n;

    function automatic mdl_t pulse_next(mdl_t m, bit u, bit d, bit tk, int hold, int rpt);
        mdl_t r = m;
        bit one_u = u && !d;
        bit one_d = d && !u;
        r.step = 1'b0;
        if (m.st == 0) begin
            if (one_u || one_d) begin
                r.step = 1'b1; r.dir = one_u; r.st = 1; r.cnt = 0;
            end
        end else if (!(m.dir ? one_u : one_d)) begin
            r.st = 0;
        end else if (tk) begin
            if (m.cnt + 1 == ((m.st == 1) ? hold : rpt)) begin
                r.step = 1'b1; r.st = 2; r.cnt = 0;
            end else begin
                r.cnt = m.cnt + 1;
            end
        end
        return r;
    endfunction

    function automatic int sat_move(int v, bit up);
        if (up) return (v < LMAX) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            lm = '{0, 0, 1'b0, 1'b0};
            mm = '{0, 0, 1'b0, 1'b0};
            m_level = 0; m_meter = 0; edge_n = 0;
        end else begin
            edge_n = edge_n + 1;
            if (lm.step) m_level = sat_move(m_level, lm.dir);
            if (mm.step) m_meter = (m_meter + 1) % 16;
            lm = pulse_next(lm, up_btn, dn_btn, (edge_n % FD) == 0, HT, RT);
            mm = pulse_next(mm, meter_btn, 1'b0, (edge_n % (FD * SD)) == 0, MT, MT);
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R3 level_step", int'(level_step), int'(lm.step));
            check("R4 level", int'(level), m_level);
            check("R8 meter_step", int'(meter_step), int'(mm.step));
            check("R9 meter_sel", int'(meter_sel), m_meter);
        end
    end

    task automatic drive(bit u, bit d, bit m, int cycles);
        @(negedge clk);
        up_btn = u; dn_btn = d; meter_btn = m;
        repeat (cycles) @(negedge clk);
        up_btn = 1'b0; dn_btn = 1'b0; meter_btn = 1'b0;
    endtask

    task automatic idle(int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1 level", int'(level), 0);
        check("R1 meter_sel", int'(meter_sel), 0);
        check("R1 level_step", int'(level_step), 0);
        check("R1 meter_step", int'(meter_step), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        idle(3);
        // R2: a single-cycle tap steps once
        drive(1'b1, 1'b0, 1'b0, 1);
        idle(4);
        check("R2 tap up", int'(level), 1);
        // R5: long lower hold floors at 0
        drive(1'b0, 1'b1, 1'b0, 200);
        idle(4);
        check("R5 floor", int'(level), 0);
        // R5: long raise hold tops out at 4095
        drive(1'b1, 1'b0, 1'b0, 17000);
        idle(4);
        check("R5 ceiling", int'(level), LMAX);
        drive(1'b1, 1'b0, 1'b0, 1);
        idle(4);
        check("R5 ceiling tap", int'(level), LMAX);
        // R6: chord gives no step
        drive(1'b1, 1'b1, 1'b0, 100);
        idle(4);
        check("R6 chord", int'(level), LMAX);
        // R4: lower tap
        drive(1'b0, 1'b1, 1'b0, 1);
        idle(4);
        check("R4 tap down", int'(level), LMAX - 1);
        // R7: release inside hold-off (minimum 16 cycles) gives only the first step
        drive(1'b0, 1'b1, 1'b0, 10);
        idle(4);
        check("R7 early release", int'(level), LMAX - 2);
        // R9: meter tap
        drive(1'b0, 1'b0, 1'b1, 1);
        idle(4);
        check("R9 meter tap", int'(meter_sel), 1);
        // random phase
        for (int i = 0; i < 2500; i++) begin
            bit u = 1'($urandom_range(0, 1));
            bit d = 1'($urandom_range(0, 1));
            bit m = 1'($urandom_range(0, 1));
            drive(u, d, m, int'($urandom_range(1, 60)));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 5)));
        end
        idle(5);
        finish_run();
    end
endmodule